// File: doc/BRIEF.md
# Dual-Rate CAN FD Bit Timing Generator

This block produces the time base that a CAN FD protocol engine runs on. It divides the module clock into time quanta and arranges quanta into bits made of a one-quantum synchronization segment, a first phase segment and a second phase segment. It strobes the start of each bit and the point where the bus level is sampled. Two parameter sets are held: a nominal set for arbitration and a data set for the fast payload phase. Each set has its own prescaler and segment lengths, all stored in minus-one form.

Software programs both sets while the generator is disabled and then raises the enable. The protocol engine drives a phase request level. The change of set takes effect at the sample point of the bit in progress, so the second phase segment of that bit already runs with the new set. The active phase is driven out so that a delay compensation unit can follow the data phase. Programming both sets alike gives a frame that runs at one rate throughout.

Top module: `cfd_bittime_gen`

## Requirements
- R1: After reset every prescaler and segment field of both sets is zero and all outputs are low. Enabling without programming gives a 3-cycle bit with a tick on every cycle.
- R2: `tq_tick` is a one-cycle pulse on every (P+1)-th cycle, where P is the prescaler field of the active set. The first tick of a bit comes P cycles after `bit_start`.
- R3: A bit lasts 1 + (S1+1) + (S2+1) quanta, where S1 and S2 are the segment fields. `bit_start` is high for exactly the first cycle of the synchronization quantum, and the first enabled cycle is such a cycle.
- R4: `sample_pt` is high for one cycle only. That cycle is the last cycle of the last first-segment quantum, (S1+2)*(P+1)-1 cycles after `bit_start`, and it coincides with a `tq_tick`.
- R5: `cfg_sel` = 0 writes the nominal set and `cfg_sel` = 1 writes the data set. The two sets are stored independently, and every bit after enable rises uses the nominal set until a switch.
- R6: `phase_req` (1 = data, 0 = nominal) is sampled in the `sample_pt` cycle. The set it names is active from the next cycle on, including the prescaler and second segment of the current bit. `data_phase` reads 1 while the data set is active.
- R7: Configuration writes are taken only while `enable` is low. A write while enabled leaves the timing unchanged.
- R8: While `enable` is low, `tq_tick`, `bit_start`, `sample_pt` and `data_phase` are all low. Raising `enable` restarts at a new bit in the nominal phase.
- R9: With both sets equal, phase changes do not alter the bit length or the sample position.
- R10: Nominal prescaler 19 with a 20-quantum bit (first field 14, second field 3, sample at 80 %) gives a 400-cycle bit, which is 500 kbit/s at 200 MHz. Data prescaler 4 with the same segments gives a 100-cycle bit, which is 2 Mbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; configuration writes are accepted only while low |
| cfg_we | input | 1 | Write strobe for one parameter set |
| cfg_sel | input | 1 | Set selector: 0 nominal, 1 data |
| cfg_brp | input | BRP_W | Prescaler field (quantum = field + 1 clocks) |
| cfg_tseg1 | input | TS1_W | First phase segment field (length = field + 1 quanta) |
| cfg_tseg2 | input | TS2_W | Second phase segment field (length = field + 1 quanta) |
| phase_req | input | 1 | Requested phase, taken at the sample point |
| tq_tick | output | 1 | One pulse per time quantum, on its last cycle |
| bit_start | output | 1 | First cycle of each bit |
| sample_pt | output | 1 | Sample strobe at the end of the first phase segment |
| data_phase | output | 1 | 1 while the data set is active |

## Verification
The checker relies on configuration being written only while the generator is idle. The bench keeps to this during normal use, and it also issues deliberate writes while enabled to show that they are dropped. The checker also assumes that `phase_req` matters only in the sample cycle. The stimulus therefore changes the request at random cycles, including inside the sample cycle, and never holds it steady around the switch. Randomly drawn field values are kept small enough that many whole bits fit in each run. Directed cases cover the all-zero reset set, equal sets and the 500 kbit/s to 2 Mbit/s pair.

// File: rtl/cfd_bt_pkg.sv
package cfd_bt_pkg;

   // number of parameter sets: index 0 nominal, index 1 data
   localparam int unsigned NUM_SETS = 2;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } seg_e;

   function automatic int unsigned wider(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfd_param_bank.sv
module cfd_param_bank
   import cfd_bt_pkg::*;
#(
   parameter int unsigned BRP_W = 10,
   parameter int unsigned TS1_W = 8,
   parameter int unsigned TS2_W = 7,
   localparam int unsigned SET_W = BRP_W + TS1_W + TS2_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         cfg_we,
   input  logic                         cfg_sel,
   input  logic [BRP_W-1:0]             cfg_brp,
   input  logic [TS1_W-1:0]             cfg_tseg1,
   input  logic [TS2_W-1:0]             cfg_tseg2,
   input  logic                         use_data,
   output logic [BRP_W-1:0]             act_brp,
   output logic [TS1_W-1:0]             act_ts1,
   output logic [TS2_W-1:0]             act_ts2,
   output logic [NUM_SETS*SET_W-1:0]    all_sets
);

   logic [SET_W-1:0] set_q [NUM_SETS];

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic take;
      assign take = cfg_we && !enable && (cfg_sel == 1'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            set_q[s] <= '0;
         end else if (take) begin
            set_q[s] <= {cfg_brp, cfg_tseg1, cfg_tseg2};
         end
      end

      assign all_sets[s*SET_W +: SET_W] = set_q[s];
   end

   logic [SET_W-1:0] act_set;
   assign act_set = use_data ? set_q[1] : set_q[0];

   assign act_brp = act_set[SET_W-1 -: BRP_W];
   assign act_ts1 = act_set[TS2_W +: TS1_W];
   assign act_ts2 = act_set[TS2_W-1:0];

endmodule

// File: rtl/cfd_tq_div.sv
module cfd_tq_div #(
   parameter int unsigned BRP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [BRP_W-1:0] brp,
   output logic             tick,
   output logic             at_first
);

   logic [BRP_W-1:0] pc_q;

   assign tick     = run && (pc_q == brp);
   assign at_first = (pc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (!run || reload || tick) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_q + BRP_W'(1);
      end
   end

endmodule

// File: rtl/cfd_seg_ctr.sv
module cfd_seg_ctr
   import cfd_bt_pkg::*;
#(
   parameter int unsigned TS1_W = 8,
   parameter int unsigned TS2_W = 7,
   localparam int unsigned CNT_W = wider(TS1_W, TS2_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             at_first,
   input  logic [TS1_W-1:0] ts1,
   input  logic [TS2_W-1:0] ts2,
   input  logic             phase_req,
   output logic             bit_start,
   output logic             sample_pt,
   output logic             phase_q,
   output logic             phase_flip
);

   seg_e             seg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             seg_end;

   always_comb begin
      unique case (seg_q)
         SEG_SYNC: seg_end = 1'b1;
         SEG_PH1:  seg_end = (cnt_q == CNT_W'(ts1));
         SEG_PH2:  seg_end = (cnt_q == CNT_W'(ts2));
         default:  seg_end = 1'b1;
      endcase
   end

   assign bit_start  = run && (seg_q == SEG_SYNC) && at_first;
   assign sample_pt  = tick && (seg_q == SEG_PH1) && seg_end;
   assign phase_flip = sample_pt && (phase_req != phase_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q   <= SEG_SYNC;
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!run) begin
         seg_q   <= SEG_SYNC;
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (tick) begin
         if (seg_end) begin
            cnt_q <= '0;
            unique case (seg_q)
               SEG_SYNC: seg_q <= SEG_PH1;
               SEG_PH1:  seg_q <= SEG_PH2;
               default:  seg_q <= SEG_SYNC;
            endcase
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (sample_pt) begin
            phase_q <= phase_req;
         end
      end
   end

endmodule

// File: rtl/cfd_bittime_gen.sv
module cfd_bittime_gen
   import cfd_bt_pkg::*;
#(
   parameter int unsigned BRP_W = 10,
   parameter int unsigned TS1_W = 8,
   parameter int unsigned TS2_W = 7,
   localparam int unsigned SET_W = BRP_W + TS1_W + TS2_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [BRP_W-1:0] cfg_brp,
   input  logic [TS1_W-1:0] cfg_tseg1,
   input  logic [TS2_W-1:0] cfg_tseg2,
   input  logic             phase_req,
   output logic             tq_tick,
   output logic             bit_start,
   output logic             sample_pt,
   output logic             data_phase
);

   if (BRP_W < 1 || BRP_W > 16) begin : g_bad_brp
      $error("cfd_bittime_gen: BRP_W must lie in 1..16");
   end
   if (TS1_W < 1 || TS1_W > 16) begin : g_bad_ts1
      $error("cfd_bittime_gen: TS1_W must lie in 1..16");
   end
   if (TS2_W < 1 || TS2_W > 16) begin : g_bad_ts2
      $error("cfd_bittime_gen: TS2_W must lie in 1..16");
   end

   logic [BRP_W-1:0]          act_brp;
   logic [TS1_W-1:0]          act_ts1;
   logic [TS2_W-1:0]          act_ts2;
   logic [NUM_SETS*SET_W-1:0] all_sets;
   logic                      phase_q;
   logic                      phase_flip;
   logic                      at_first;

   cfd_param_bank #(
      .BRP_W (BRP_W),
      .TS1_W (TS1_W),
      .TS2_W (TS2_W)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_brp   (cfg_brp),
      .cfg_tseg1 (cfg_tseg1),
      .cfg_tseg2 (cfg_tseg2),
      .use_data  (phase_q),
      .act_brp   (act_brp),
      .act_ts1   (act_ts1),
      .act_ts2   (act_ts2),
      .all_sets  (all_sets)
   );

   cfd_tq_div #(
      .BRP_W (BRP_W)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (enable),
      .reload   (phase_flip),
      .brp      (act_brp),
      .tick     (tq_tick),
      .at_first (at_first)
   );

   cfd_seg_ctr #(
      .TS1_W (TS1_W),
      .TS2_W (TS2_W)
   ) seg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (enable),
      .tick       (tq_tick),
      .at_first   (at_first),
      .ts1        (act_ts1),
      .ts2        (act_ts2),
      .phase_req  (phase_req),
      .bit_start  (bit_start),
      .sample_pt  (sample_pt),
      .phase_q    (phase_q),
      .phase_flip (phase_flip)
   );

   assign data_phase = enable && phase_q;

endmodule

// File: rtl/cfd_bittime_chk.sv
module cfd_bittime_chk #(
   parameter int unsigned FLAT_W = 50
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              tq_tick,
   input logic              bit_start,
   input logic              sample_pt,
   input logic              data_phase,
   input logic [FLAT_W-1:0] all_sets
);

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |=> !bit_start);

   assert_start_not_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |-> !sample_pt);

   assert_sample_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |=> !sample_pt);

   assert_sample_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |-> tq_tick);

   assert_phase_at_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && (data_phase != $past(data_phase))) |-> $past(sample_pt));

   assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(all_sets));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!tq_tick && !bit_start && !sample_pt && !data_phase));

endmodule

bind cfd_bittime_gen cfd_bittime_chk #(
   .FLAT_W (cfd_bt_pkg::NUM_SETS * (BRP_W + TS1_W + TS2_W))
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .tq_tick    (tq_tick),
   .bit_start  (bit_start),
   .sample_pt  (sample_pt),
   .data_phase (data_phase),
   .all_sets   (all_sets)
);

// File: tb/cfd_bittime_gen_tb_top.sv
`timescale 1ns/1ps
module cfd_bittime_gen_tb_top;

   localparam int BRP_W = 10;
   localparam int TS1_W = 8;
   localparam int TS2_W = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic cfg_we = 1'b0;
   logic cfg_sel = 1'b0;
   logic [BRP_W-1:0] cfg_brp = '0;
   logic [TS1_W-1:0] cfg_tseg1 = '0;
   logic [TS2_W-1:0] cfg_tseg2 = '0;
   logic phase_req = 1'b0;
   logic tq_tick, bit_start, sample_pt, data_phase;

   always #5 clk = ~clk;

   cfd_bittime_gen #(.BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2),
      .phase_req(phase_req), .tq_tick(tq_tick), .bit_start(bit_start),
      .sample_pt(sample_pt), .data_phase(data_phase)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // model of the programmed sets: 0 nominal, 1 data
   int m_brp [2] = '{0, 0};
   int m_ts1 [2] = '{0, 0};
   int m_ts2 [2] = '{0, 0};

   // model timing state
   bit m_run = 1'b0;
   int t = 0, p = 0, q = 0, blen = -1;
   int cyc = 0, last_st = -1, last_iv = 0;
   bit new_iv = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
      end
   endtask

   // called at a falling edge after the inputs are driven; returns at the next falling edge
   task automatic step(input string ctx);
      int bp, bq, s;
      bit e_tick, e_start, e_samp, e_phase;
      #1;
      cyc++;
      new_iv = 1'b0;
      if (!enable) begin
         m_run = 1'b0;
         check(!tq_tick && !bit_start && !sample_pt && !data_phase,
               {"R8 idle ", ctx}, {tq_tick, bit_start, sample_pt, data_phase}, 0);
      end else begin
         if (!m_run) begin
            m_run = 1'b1; t = 0; p = 0; blen = -1;
         end
         bp = m_brp[p] + 1;
         s  = (m_ts1[p] + 2) * bp - 1;
         bq = m_brp[q] + 1;
         e_start = (t == 0);
         e_samp  = (t == s);
         if (t <= s) begin
            e_tick  = ((t + 1) % bp) == 0;
            e_phase = p[0];
         end else begin
            e_tick  = ((t - s) % bq) == 0;
            e_phase = q[0];
         end
         check(tq_tick == e_tick,     {"R2 tick ", ctx},   tq_tick, e_tick);
         check(bit_start == e_start,  {"R3 start ", ctx},  bit_start, e_start);
         check(sample_pt == e_samp,   {"R4 sample ", ctx}, sample_pt, e_samp);
         check(data_phase == e_phase, {"R6 phase ", ctx},  data_phase, e_phase);
         if (t == s) begin
            q    = int'(phase_req);
            bq   = m_brp[q] + 1;
            blen = s + 1 + (m_ts2[q] + 1) * bq;
         end
         t++;
         if (t == blen) begin
            t = 0; p = q; blen = -1;
         end
      end
      if (bit_start) begin
         if (last_st >= 0) begin
            last_iv = cyc - last_st;
            new_iv  = 1'b1;
         end
         last_st = cyc;
      end
      if (!enable) last_st = -1;
      @(negedge clk);
   endtask

   task automatic write_set(input int sel, input int b, input int a, input int c);
      cfg_we = 1'b1; cfg_sel = sel[0];
      cfg_brp = BRP_W'(b); cfg_tseg1 = TS1_W'(a); cfg_tseg2 = TS2_W'(c);
      if (!enable) begin
         m_brp[sel] = b; m_ts1[sel] = a; m_ts2[sel] = c;
      end
      step("cfg");
      cfg_we = 1'b0;
   endtask

   task automatic go_idle();
      enable = 1'b0;
      step("idle");
      step("idle");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      // R1: outputs low in reset
      #1;
      check(!tq_tick && !bit_start && !sample_pt && !data_phase, "R1 reset outputs",
            {tq_tick, bit_start, sample_pt, data_phase}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step("R1 post reset");
      // R1: unprogrammed sets are all zero -> 3-cycle bits, tick every cycle
      enable = 1'b1;
      for (int i = 0; i < 12; i++) begin
         step("R1 zero set");
         if (new_iv) check(last_iv == 3, "R1 zero-set bit length", last_iv, 3);
      end
      go_idle();

      // R10: 500 kbit/s nominal and 2 Mbit/s data at 200 MHz
      write_set(0, 19, 14, 3);
      write_set(1, 4, 14, 3);
      phase_req = 1'b0;
      enable = 1'b1;
      for (int i = 0; i < 1300; i++) begin
         step("R10 nominal");
         if (new_iv) check(last_iv == 400, "R10 nominal bit cycles", last_iv, 400);
      end
      phase_req = 1'b1;
      for (int i = 0; i < 900; i++) begin
         step("R10 switch");
      end
      for (int i = 0; i < 500; i++) begin
         step("R10 data");
         if (new_iv) check(last_iv == 100, "R10 data bit cycles", last_iv, 100);
      end
      // R8: drop enable in data phase, re-enable restarts nominal
      go_idle();
      phase_req = 1'b1;
      enable = 1'b1;
      for (int i = 0; i < 420; i++) step("R8 restart");
      go_idle();

      // R9: equal sets, phase requests toggle freely
      write_set(0, 2, 3, 2);
      write_set(1, 2, 3, 2);
      enable = 1'b1;
      for (int i = 0; i < 600; i++) begin
         if (($urandom % 5) == 0) phase_req = ~phase_req;
         step("R9 equal sets");
         if (new_iv) check(last_iv == 24, "R9 equal-set bit length", last_iv, 24);
      end
      go_idle();

      // R5/R6/R7: random independent sets, random phase requests, writes while enabled
      for (int k = 0; k < 25; k++) begin
         write_set(0, $urandom % 6, $urandom % 7, $urandom % 5);
         write_set(1, $urandom % 4, $urandom % 5, $urandom % 4);
         phase_req = 1'(($urandom % 2));
         enable = 1'b1;
         for (int c = 0; c < 400; c++) begin
            if (($urandom % 9) == 0) phase_req = ~phase_req;
            if (c == 40 || c == 211) begin
               write_set(int'($urandom % 2), $urandom % 60, $urandom % 60, $urandom % 60);
            end else begin
               step((k % 2) ? "R5 random" : "R7 random");
            end
         end
         go_idle();
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule